// File: doc/BRIEF.md
# Key Sequencer and Trigger Arbiter

This block sits in front of a sentence playback engine and decides which sentence the engine plays next. It watches one single-key trigger and three stand-alone triggers, all active-high and already cleaned of bounce. A rising level on any trigger is an event. When more than one event arrives in the same clock, a fixed priority picks one winner. The winner becomes a start request carrying a sentence index. A stand-alone trigger always maps to its own configured index. The single key picks its index from a programmable list of up to 16 entries.

The single key has three selection modes. Play-next steps through the list one entry per press. Random draws the entry from a 4-bit linear feedback shift register. Play-all plays the whole list back to back, advancing each time the engine's busy flag falls. While the engine is busy, a new event either pre-empts the current playback or is dropped, depending on the selected policy. Pre-emption emits a stop pulse and then a start pulse. A key on/off option lets a single-key press during playback stop the engine instead of starting anything.

Top module: `keyseq_arbiter`

## Requirements
- R1: A start request is raised only by a rising edge of a trigger. With `busy_i` low, `start_o` pulses in the cycle after the clock edge that first sees the trigger high, with `idx_o` valid in that same cycle. A trigger that stays high raises no further request.
- R2: Events in the same cycle resolve as stand-alone 2 above stand-alone 1 above stand-alone 0 above the single key. Stand-alone k is `trig_sa_i[k]` and takes its index from `sa_idx_i[k*6 +: 6]`. A key event that loses arbitration leaves the key selection state unchanged.
- R3: In play-next mode (`key_mode_i` = 0, or the unused code 3), each key start issues list entry `key_list_i[p*6 +: 6]` for pointer p. The pointer starts at 0, advances by one per key start, and returns to 0 after the last entry of the effective count. The effective count is `key_count_i`, with 0 treated as 1 and values above 16 treated as 16.
- R4: In random mode (`key_mode_i` = 1), a key start issues the entry at slot (s mod count), where s is a 4-bit register. s starts at 1 and steps to {s[2:0], s[3]^s[2]} after each random key start, so it never becomes 0.
- R5: In play-all mode (`key_mode_i` = 2), a key start issues entry 0. After that, each falling edge of `busy_i` starts the next entry one cycle after the clock that first sees `busy_i` low. This continues until count entries have been issued. Later falling edges then start nothing.
- R6: Under last-key priority (`last_key_pri_i` = 1), an event while `busy_i` is high gives a one-cycle `stop_o` in the cycle after the event, then `start_o` with the new index in the cycle after that.
- R7: Under first-key priority (`last_key_pri_i` = 0), an event while `busy_i` is high gives no start and no stop. It also leaves the key selection state unchanged.
- R8: With `key_toggle_en_i` = 1, a winning key event while `busy_i` is high gives a `stop_o` pulse and no start. It cancels a play-all run and does not move the play-next pointer.
- R9: While reset is held, and after it is released, `start_o`, `stop_o` and `idx_o` are 0. The play-next pointer is 0, the random register is 1, and no play-all run is active.
- R10: Trigger edges that arrive in the cycle between a pre-emption stop and its start are ignored. Any start or stop caused by an event ends a play-all run, unless that event is itself a play-all key start. A new event wins over a play-all advance in the same cycle.
- R11: `start_o` and `stop_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_key_i | input | 1 | Single-key trigger level |
| trig_sa_i | input | 3 | Stand-alone trigger levels, bit k is stand-alone k |
| busy_i | input | 1 | Playback engine busy flag |
| key_mode_i | input | 2 | 0 play-next, 1 random, 2 play-all, 3 as play-next |
| last_key_pri_i | input | 1 | 1 newer event pre-empts, 0 current playback kept |
| key_toggle_en_i | input | 1 | Key press while busy stops playback |
| key_count_i | input | 5 | Number of list entries used by the single key |
| key_list_i | input | 96 | Key list, entry j at bits j*6 +: 6 |
| sa_idx_i | input | 18 | Stand-alone indices, input k at bits k*6 +: 6 |
| start_o | output | 1 | One-cycle start request to the engine |
| stop_o | output | 1 | One-cycle stop request to the engine |
| idx_o | output | 6 | Sentence index, valid while start_o is high |

## Verification
All outputs are registered. An accepted idle event shows as `start_o` one cycle after the clock that samples it. A pre-emption shows as `stop_o` at that same point and `start_o` one cycle later. A play-all advance shows one cycle after the clock that first sees `busy_i` low. The bench changes inputs on the falling clock edge and reads outputs on the next falling edge, so every read lands exactly one register stage after its cause. Where a pulse must not recur, the bench reads the cycle after it as well. A pre-emption is checked across both cycles, and dropped or cancelled events are checked by seeing no pulse in the cycles where one would otherwise appear.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  typedef enum logic [1:0] {
    KM_NEXT = 2'd0,
    KM_RAND = 2'd1,
    KM_ALL  = 2'd2,
    KM_RSVD = 2'd3
  } key_mode_e;

  // One step of the 4-bit selection register, taps on bits 3 and 2.
  function automatic logic [3:0] lfsr4_next(input logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  // Effective list length: zero means one, anything beyond depth means depth.
  function automatic int unsigned clamp_count(input int unsigned raw,
                                              input int unsigned depth);
    if (raw == 0) return 1;
    if (raw > depth) return depth;
    return raw;
  endfunction

  // Reduce a raw value to a slot in a list of n entries (n >= 1).
  function automatic int unsigned wrap_slot(input int unsigned v,
                                            input int unsigned n);
    return v % n;
  endfunction

endpackage

// File: rtl/ks_edge_det.sv
module ks_edge_det #(
  parameter int unsigned N       = 4,
  parameter bit          FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] ev_o
);

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  generate
    for (genvar i = 0; i < int'(N); i++) begin : g_bit
      if (FALLING) begin : g_fall
        assign ev_o[i] = lvl_q[i] & ~lvl_i[i];
      end else begin : g_rise
        assign ev_o[i] = lvl_i[i] & ~lvl_q[i];
        // R1: a rise is reported only once while the level stays high
        assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
          ev_o[i] |=> !ev_o[i]);
      end
    end
  endgenerate

endmodule

// File: rtl/ks_prio_arb.sv
module ks_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  // Highest index wins.
  generate
    for (genvar i = 0; i < int'(N); i++) begin : g_grant
      if (i == int'(N) - 1) begin : g_top
        assign grant_o[i] = req_i[i];
      end else begin : g_low
        assign grant_o[i] = req_i[i] & ~(|req_i[N-1:i+1]);
      end
    end
  endgenerate

  assign any_o = |req_i;

  assert_one_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> $onehot(grant_o));

  assert_key_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[0] |-> (req_i[N-1:1] == '0));

endmodule

// File: rtl/ks_key_seq.sv
module ks_key_seq
  import keyseq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [DEPTH*IDX_W-1:0] list_i,
  input  logic                   commit_i,
  input  logic                   cancel_i,
  input  logic                   step_i,
  output logic [IDX_W-1:0]       pick_idx_o,
  output logic                   all_fire_o,
  output logic [IDX_W-1:0]       all_idx_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  key_mode_e          mode;
  logic [IDX_W-1:0]   ent [DEPTH];
  logic [CNT_W-1:0]   eff;
  logic [PTR_W-1:0]   ptr_q;
  logic [CNT_W-1:0]   aptr_q;
  logic               run_q;
  logic [3:0]         lfsr_q;
  logic [PTR_W-1:0]   rand_slot;
  logic [CNT_W-1:0]   ptr_inc;
  logic               ptr_valid;

  assign mode = key_mode_e'(mode_i);

  generate
    for (genvar j = 0; j < int'(DEPTH); j++) begin : g_ent
      assign ent[j] = list_i[j*IDX_W +: IDX_W];
    end
  endgenerate

  assign eff       = CNT_W'(clamp_count(int'(count_i), DEPTH));
  assign rand_slot = PTR_W'(wrap_slot(int'(lfsr_q), int'(eff)));
  assign ptr_valid = CNT_W'(ptr_q) < eff;
  assign ptr_inc   = CNT_W'(ptr_q) + CNT_W'(1);

  always_comb begin
    unique case (mode)
      KM_RAND: pick_idx_o = ent[rand_slot];
      KM_ALL:  pick_idx_o = ent[0];
      default: pick_idx_o = ptr_valid ? ent[ptr_q] : ent[0];
    endcase
  end

  assign all_fire_o = run_q & step_i & (aptr_q < eff);
  assign all_idx_o  = ent[aptr_q[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      aptr_q <= '0;
      run_q  <= 1'b0;
      lfsr_q <= 4'd1;
    end else if (commit_i) begin
      run_q <= (mode == KM_ALL);
      unique case (mode)
        KM_RAND: lfsr_q <= lfsr4_next(lfsr_q);
        KM_ALL:  aptr_q <= CNT_W'(1);
        default: ptr_q  <= (!ptr_valid || ptr_inc >= eff) ? '0 : PTR_W'(ptr_inc);
      endcase
    end else if (cancel_i) begin
      run_q <= 1'b0;
    end else if (run_q && step_i) begin
      if (aptr_q < eff) aptr_q <= aptr_q + CNT_W'(1);
      else              run_q  <= 1'b0;
    end
  end

  assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 4'd0);

  assert_aptr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (aptr_q <= CNT_W'(DEPTH)));

  assert_fire_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    all_fire_o |-> step_i);

endmodule

// File: rtl/keyseq_arbiter.sv
module keyseq_arbiter
  import keyseq_pkg::*;
#(
  parameter int unsigned LIST_DEPTH = 16,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned NUM_SA     = 3,
  parameter int unsigned CNT_W      = $clog2(LIST_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig_key_i,
  input  logic [NUM_SA-1:0]           trig_sa_i,
  input  logic                        busy_i,
  input  logic [1:0]                  key_mode_i,
  input  logic                        last_key_pri_i,
  input  logic                        key_toggle_en_i,
  input  logic [CNT_W-1:0]            key_count_i,
  input  logic [LIST_DEPTH*IDX_W-1:0] key_list_i,
  input  logic [NUM_SA*IDX_W-1:0]     sa_idx_i,
  output logic                        start_o,
  output logic                        stop_o,
  output logic [IDX_W-1:0]            idx_o
);

  localparam int unsigned NREQ = NUM_SA + 1;

  logic [NREQ-1:0]  rise;
  logic [NREQ-1:0]  grant;
  logic             any_rise;
  logic [0:0]       busy_fall_v;
  logic             busy_fall;

  // Named decision wires for the checks below.
  logic             ev;
  logic             key_off;
  logic             drop;
  logic             preempt;
  logic             direct;
  logic             key_commit;
  logic             cancel;
  logic             step;
  logic [IDX_W-1:0] key_pick;
  logic [IDX_W-1:0] sel_idx;
  logic             all_fire;
  logic [IDX_W-1:0] all_idx;

  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;

  ks_edge_det #(.N(NREQ), .FALLING(1'b0)) u_trig_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl_i({trig_sa_i, trig_key_i}),
    .ev_o (rise)
  );

  ks_edge_det #(.N(1), .FALLING(1'b1)) u_busy_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl_i(busy_i),
    .ev_o (busy_fall_v)
  );
  assign busy_fall = busy_fall_v[0];

  ks_prio_arb #(.N(NREQ)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (rise),
    .grant_o(grant),
    .any_o  (any_rise)
  );

  ks_key_seq #(.DEPTH(LIST_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (key_mode_i),
    .count_i   (key_count_i),
    .list_i    (key_list_i),
    .commit_i  (key_commit),
    .cancel_i  (cancel),
    .step_i    (step),
    .pick_idx_o(key_pick),
    .all_fire_o(all_fire),
    .all_idx_o (all_idx)
  );

  always_comb begin
    sel_idx = key_pick;
    for (int k = 0; k < int'(NUM_SA); k++) begin
      if (grant[k+1]) sel_idx = sa_idx_i[k*IDX_W +: IDX_W];
    end
  end

  // Edges are ignored in the cycle between a pre-emption stop and its start.
  assign ev         = any_rise & ~pend_q;
  assign key_off    = ev & grant[0] & busy_i & key_toggle_en_i;
  assign drop       = ev & busy_i & ~last_key_pri_i & ~key_off;
  assign preempt    = ev & busy_i &  last_key_pri_i & ~key_off;
  assign direct     = ev & ~busy_i;
  assign key_commit = grant[0] & (direct | preempt);
  assign cancel     = direct | preempt | key_off;
  assign step       = busy_fall & ~pend_q & ~direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      idx_o      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      stop_o  <= key_off | preempt;
      start_o <= direct | pend_q | all_fire;
      pend_q  <= preempt;
      if (preempt) pend_idx_q <= sel_idx;
      if (direct)        idx_o <= sel_idx;
      else if (pend_q)   idx_o <= pend_idx_q;
      else if (all_fire) idx_o <= all_idx;
    end
  end

  assert_direct_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    direct |=> (start_o && !stop_o));

  assert_preempt_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |=> (stop_o && !start_o) ##1 start_o);

  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!start_o && !stop_o));

  assert_key_off_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_off |=> (stop_o && !start_o));

  assert_pend_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !(direct || preempt || key_off));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));

endmodule

// File: tb/sim_keyseq_arbiter.sv
module sim_keyseq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_key = 1'b0;
  logic [2:0]  trig_sa = 3'b0;
  logic        busy = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        lkp = 1'b0;
  logic        tog = 1'b0;
  logic [4:0]  cnt = 5'd3;
  logic [95:0] list;
  logic [17:0] saidx;
  logic        start, stop;
  logic [5:0]  idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit both_seen = 1'b0;

  always #4 clk = ~clk;

  keyseq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .trig_key_i(trig_key), .trig_sa_i(trig_sa),
    .busy_i(busy), .key_mode_i(mode), .last_key_pri_i(lkp),
    .key_toggle_en_i(tog), .key_count_i(cnt), .key_list_i(list),
    .sa_idx_i(saidx), .start_o(start), .stop_o(stop), .idx_o(idx)
  );

  initial begin
    for (int j = 0; j < 16; j++) list[j*6 +: 6] = 6'(10 + j);
    saidx = {6'd42, 6'd41, 6'd40};
  end

  always @(negedge clk) if (rst_n && start && stop) both_seen = 1'b1;

  typedef struct packed {
    logic       busy;
    logic       lkp;
    logic [3:0] trig;   // {sa2, sa1, sa0, key}
    logic       s1;
    logic       p1;
    logic       s2;
    logic [5:0] idx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 6'd10}, // R1 R3 entry 0
    '{1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 6'd11}, // R3
    '{1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 6'd12}, // R3 last entry
    '{1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 6'd10}, // R3 wrap
    '{1'b0, 1'b0, 4'b1111, 1'b1, 1'b0, 1'b0, 6'd42}, // R2
    '{1'b0, 1'b0, 4'b0111, 1'b1, 1'b0, 1'b0, 6'd41}, // R2
    '{1'b0, 1'b0, 4'b0011, 1'b1, 1'b0, 1'b0, 6'd40}, // R2
    '{1'b1, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b0, 6'd0 }, // R7
    '{1'b1, 1'b1, 4'b0010, 1'b0, 1'b1, 1'b1, 6'd40}, // R6
    '{1'b1, 1'b1, 4'b0001, 1'b0, 1'b1, 1'b1, 6'd11}, // R6, pointer kept by R2
    '{1'b1, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 6'd0 }, // R7
    '{1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 6'd12}  // R7 pointer unchanged
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press_key();
    trig_key = 1'b1;
    step();
  endtask

  function automatic int ref_next(input int s);
    return ((s << 1) & 15) | (((s >> 3) ^ (s >> 2)) & 1);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(start, 0, "R9 start in reset");
    chk(stop,  0, "R9 stop in reset");
    rst_n = 1'b1;
    step();
    chk(start, 0, "R9 start after reset");
    chk(stop,  0, "R9 stop after reset");
    chk(idx,   0, "R9 idx after reset");

    // Vector table: play-next mode, count 3.
    for (int v = 0; v < NV; v++) begin
      busy = VECS[v].busy;
      lkp  = VECS[v].lkp;
      {trig_sa, trig_key} = VECS[v].trig;
      step();
      chk(start, VECS[v].s1, $sformatf("vec %0d start1 R1/R2/R3/R6/R7", v));
      chk(stop,  VECS[v].p1, $sformatf("vec %0d stop1 R6/R7", v));
      if (VECS[v].s1) chk(idx, VECS[v].idx, $sformatf("vec %0d idx1 R2/R3", v));
      {trig_sa, trig_key} = 4'b0;
      step();
      chk(start, VECS[v].s2, $sformatf("vec %0d start2 R6", v));
      chk(stop,  0,          $sformatf("vec %0d stop2 R6", v));
      if (VECS[v].s2) chk(idx, VECS[v].idx, $sformatf("vec %0d idx2 R6", v));
      step();
    end
    busy = 1'b0;
    lkp  = 1'b0;

    // R1: a held trigger starts once.
    press_key();
    chk(start, 1, "R1 held first");
    chk(idx, 10, "R1 held idx");
    step();
    chk(start, 0, "R1 held no repeat");
    step();
    chk(start, 0, "R1 held no repeat 2");
    trig_key = 1'b0;
    step();

    // R3: count 0 acts as one entry.
    cnt = 5'd0;
    for (int n = 0; n < 2; n++) begin
      press_key();
      chk(idx, 10, "R3 count zero idx");
      trig_key = 1'b0;
      step();
    end
    cnt = 5'd3;

    // R4: random mode, count 5.
    mode = 2'd1;
    cnt  = 5'd5;
    s = 1;
    for (int n = 0; n < 6; n++) begin
      press_key();
      chk(start, 1, "R4 random start");
      chk(idx, 10 + (s % 5), "R4 random idx");
      s = ref_next(s);
      trig_key = 1'b0;
      step();
    end

    // R5: play-all over three entries.
    mode = 2'd2;
    cnt  = 5'd3;
    press_key();
    chk(idx, 10, "R5 play-all first");
    trig_key = 1'b0;
    for (int n = 1; n < 3; n++) begin
      busy = 1'b1;
      step();
      step();
      chk(start, 0, "R5 no start while busy");
      busy = 1'b0;
      step();
      chk(start, 1, "R5 advance on busy fall");
      chk(idx, 10 + n, "R5 advance idx");
    end
    busy = 1'b1;
    step();
    step();
    busy = 1'b0;
    step();
    chk(start, 0, "R5 list exhausted");
    step();
    chk(start, 0, "R5 list exhausted 2");

    // R8: key on/off during play-all.
    tog = 1'b1;
    press_key();
    chk(idx, 10, "R8 play-all start");
    trig_key = 1'b0;
    busy = 1'b1;
    step();
    step();
    press_key();
    chk(stop, 1, "R8 key off stop");
    chk(start, 0, "R8 key off no start");
    trig_key = 1'b0;
    step();
    chk(start, 0, "R8 key off no later start");
    busy = 1'b0;
    step();
    chk(start, 0, "R8 run cancelled");
    step();
    tog = 1'b0;

    // R10: edge in the pending cycle is ignored.
    lkp = 1'b1;
    busy = 1'b1;
    trig_sa = 3'b001;
    step();
    chk(stop, 1, "R10 pre-empt stop");
    trig_sa = 3'b100;
    step();
    chk(start, 1, "R10 pending start");
    chk(idx, 40, "R10 pending idx");
    step();
    chk(start, 0, "R10 ignored edge start");
    chk(stop, 0, "R10 ignored edge stop");
    trig_sa = 3'b000;
    busy = 1'b0;
    lkp = 1'b0;
    step();

    // R10: stand-alone start ends a play-all run and wins over the advance.
    press_key();
    chk(idx, 10, "R10 play-all start");
    trig_key = 1'b0;
    busy = 1'b1;
    step();
    busy = 1'b0;
    trig_sa = 3'b010;
    step();
    chk(start, 1, "R10 stand-alone start");
    chk(idx, 41, "R10 stand-alone idx");
    trig_sa = 3'b000;
    busy = 1'b1;
    step();
    step();
    busy = 1'b0;
    step();
    chk(start, 0, "R10 run ended");
    step();

    chk(int'(both_seen), 0, "R11 start and stop together");
    done = 1'b1;
    finish_run();
  end

endmodule